// File: doc/BRIEF.md
# Digital Integrating Bias Current Loop

This block is one channel of a digital bias current controller. It drives a 12-bit DAC code and reads back a 12-bit ADC code that measures the controlled current. A periodic tick marks each control interval. In closed-loop operation, each tick adds the difference between a ramped setpoint and the most recent sense sample to a signed accumulator. The accumulator's upper bits become the DAC code. In open-loop operation, the DAC code is taken directly from a data input. While the loop is open, the accumulator is preloaded from that data input, so that closing the loop starts from the same code.

A clamp input overrides the DAC code with a clamp code and stops sense conversions. The accumulator is frozen meanwhile, so the output returns to its pre-clamp value on release. A resume-hold option keeps conversions off after release until an explicit restart pulse, which gives the drain current time to settle. A high alarm flags DAC codes above a programmable threshold. The setpoint is not applied in one jump: a ramp stage approaches it by a bounded step each tick.

Top module: `bias_loop_ctrl`

## Requirements
- R1: While reset is asserted, and for the two clocks after release while the internal synchronizer fills, `dac_code_o`, `conv_en_o` and `alarm_o` are all 0.
- R2: With `loop_en_i`=0 and `clamp_i`=0, `dac_code_o` equals the `ol_data_i` value sampled at the previous clock edge.
- R3: A tick occurs once every `TICK_CYC` clocks. With `loop_en_i`=1 and no clamp, each tick adds (ramp code − held sample), as a signed value, to the accumulator. `dac_code_o` is the accumulator shifted right by `FRAC_W`, and it updates at the same edge as the accumulator.
- R4: A tick adds error only if an accepted ADC sample (`adc_valid_i`=1 while `conv_en_o`=1) arrived after the previous tick. Otherwise the accumulator is unchanged.
- R5: At each tick the ramp code moves toward `setpoint_i` by at most 2^(11−min(`ramp_sel_i`,11)), and lands exactly on it when the remaining distance is within one step.
- R6: The accumulator is held within 0 and 2^(12+`FRAC_W`)−1. A sum outside that range is saturated, so no windup builds up, and an opposing error moves the output off the rail at the next tick.
- R7: With `clamp_i`=1, `dac_code_o` equals `clamp_code_i` one clock later. The accumulator does not change while clamped, so after release the output is the pre-clamp code.
- R8: `conv_en_o` is 0 in the clock after `clamp_i` is seen high. ADC strobes are ignored while `conv_en_o` is 0.
- R9: If `resume_hold_i` was 1 during the clamp, `conv_en_o` stays 0 after release until a `conv_restart_i` pulse is seen. It then goes high one clock later.
- R10: `alarm_o` is 1 exactly when `alarm_en_i` was 1 and the new `dac_code_o` is strictly greater than `alarm_thr_i`. It is registered alongside the DAC code.
- R11: While `loop_en_i`=0, the accumulator is loaded with `ol_data_i` scaled by 2^`FRAC_W`. After the loop is enabled, the DAC code therefore starts at the open-loop code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| loop_en_i | input | 1 | 1 selects closed-loop operation |
| clamp_i | input | 1 | Force clamp code and stop sensing |
| resume_hold_i | input | 1 | Keep conversions off after clamp release |
| conv_restart_i | input | 1 | Pulse re-enabling conversions after a hold |
| setpoint_i | input | 12 | Target sense code |
| ramp_sel_i | input | 4 | Ramp step select (larger is slower) |
| adc_valid_i | input | 1 | ADC sample strobe |
| adc_data_i | input | 12 | ADC sense code |
| ol_data_i | input | 12 | Open-loop DAC code |
| clamp_code_i | input | 12 | DAC code used while clamped |
| alarm_en_i | input | 1 | High alarm enable |
| alarm_thr_i | input | 12 | High alarm threshold |
| dac_code_o | output | 12 | DAC code |
| conv_en_o | output | 1 | Sense conversion enable |
| alarm_o | output | 1 | High alarm |

## Verification
Two cases can land in the same clock, and both are tested. In the first, a clamp rises on the clock of a tick while a fresh sample is waiting; the accumulator must then hold, and the output must still switch to the clamp code. In the second, an ADC strobe arrives on the very tick that clears the fresh flag; the sample must count toward the next interval, not the current one. Random stimulus toggles clamp, loop enable and strobes independently, with a short tick period, so both collisions recur many times. A cycle-level bench model judges every output on every clock.

// File: rtl/blc_pkg.sv
package blc_pkg;

  typedef enum logic [1:0] {
    SRC_OPEN  = 2'd0,
    SRC_LOOP  = 2'd1,
    SRC_CLAMP = 2'd2
  } dac_src_e;

  // Largest ramp step per tick for a given select value.
  function automatic int unsigned ramp_step(input int unsigned dw, input logic [3:0] sel);
    int unsigned sh;
    sh = (32'(sel) > dw - 1) ? dw - 1 : 32'(sel);
    return 32'd1 << (dw - 1 - sh);
  endfunction

endpackage

// File: rtl/blc_tick_gen.sv
module blc_tick_gen #(
  parameter int unsigned TICK_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/blc_setpoint_ramp.sv
module blc_setpoint_ramp
  import blc_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-1:0] target_i,
  input  logic [3:0]    sel_i,
  output logic [DW-1:0] ramp_o
);
  localparam int unsigned XW = DW + 2;

  logic [DW-1:0]        ramp_q, ramp_d;
  logic signed [XW-1:0] diff, step_s;

  always_comb begin
    step_s = $signed(XW'(ramp_step(DW, sel_i)));
    diff   = $signed({2'b00, target_i}) - $signed({2'b00, ramp_q});
    ramp_d = ramp_q;
    if (tick_i) begin
      if (diff > step_s)       ramp_d = ramp_q + DW'(step_s);
      else if (diff < -step_s) ramp_d = ramp_q - DW'(step_s);
      else                     ramp_d = target_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ramp_q <= '0;
    else         ramp_q <= ramp_d;
  end

  assign ramp_o = ramp_q;
endmodule

// File: rtl/blc_integrator.sv
module blc_integrator #(
  parameter int unsigned DW     = 12,
  parameter int unsigned FRAC_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 loop_en_i,
  input  logic                 freeze_i,
  input  logic                 fresh_i,
  input  logic [DW-1:0]        ramp_i,
  input  logic [DW-1:0]        sample_i,
  input  logic [DW-1:0]        preload_i,
  output logic [DW+FRAC_W-1:0] acc_o,
  output logic [DW-1:0]        code_next_o
);
  localparam int unsigned AW = DW + FRAC_W;
  localparam int unsigned SW = AW + 2;
  localparam logic [AW-1:0] ACC_MAX = '1;

  logic [AW-1:0]        acc_q, acc_d;
  logic signed [DW:0]   err;
  logic signed [SW-1:0] err_x, sum;
  logic                 step_en;

  always_comb begin
    err     = $signed({1'b0, ramp_i}) - $signed({1'b0, sample_i});
    err_x   = {{(SW-DW-1){err[DW]}}, err};
    sum     = $signed({2'b00, acc_q}) + err_x;
    step_en = tick_i && !freeze_i && fresh_i;
    acc_d   = acc_q;
    if (!loop_en_i) begin
      acc_d = {preload_i, {FRAC_W{1'b0}}};
    end else if (step_en) begin
      if (sum < 0)                             acc_d = '0;
      else if (sum > $signed({2'b00, ACC_MAX})) acc_d = ACC_MAX;
      else                                     acc_d = sum[AW-1:0];
    end
    code_next_o = acc_d[AW-1:FRAC_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/bias_loop_ctrl.sv
module bias_loop_ctrl
  import blc_pkg::*;
#(
  parameter int unsigned DW       = 12,
  parameter int unsigned FRAC_W   = 6,
  parameter int unsigned TICK_CYC = 50000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          loop_en_i,
  input  logic          clamp_i,
  input  logic          resume_hold_i,
  input  logic          conv_restart_i,
  input  logic [DW-1:0] setpoint_i,
  input  logic [3:0]    ramp_sel_i,
  input  logic          adc_valid_i,
  input  logic [DW-1:0] adc_data_i,
  input  logic [DW-1:0] ol_data_i,
  input  logic [DW-1:0] clamp_code_i,
  input  logic          alarm_en_i,
  input  logic [DW-1:0] alarm_thr_i,
  output logic [DW-1:0] dac_code_o,
  output logic          conv_en_o,
  output logic          alarm_o
);
  localparam int unsigned AW = DW + FRAC_W;

  // reset synchronizer: asserts at once, releases after two clocks
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic          tick;
  logic [DW-1:0] ramp_code;
  logic [AW-1:0] acc_q;
  logic [DW-1:0] loop_code;

  blc_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (core_rst_n),
    .tick_o (tick)
  );

  blc_setpoint_ramp #(.DW(DW)) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (core_rst_n),
    .tick_i   (tick),
    .target_i (setpoint_i),
    .sel_i    (ramp_sel_i),
    .ramp_o   (ramp_code)
  );

  // sample capture: held sample plus "arrived since last tick" flag
  logic [DW-1:0] samp_q, samp_d;
  logic          fresh_q, fresh_d;
  logic          samp_take;

  always_comb begin
    samp_take = adc_valid_i && conv_en_o;
    samp_d    = samp_take ? adc_data_i : samp_q;
    fresh_d   = fresh_q;
    if (samp_take) fresh_d = 1'b1;
    else if (tick) fresh_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) begin
      samp_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      samp_q  <= samp_d;
      fresh_q <= fresh_d;
    end
  end

  blc_integrator #(.DW(DW), .FRAC_W(FRAC_W)) u_integ (
    .clk_i       (clk_i),
    .rst_ni      (core_rst_n),
    .tick_i      (tick),
    .loop_en_i   (loop_en_i),
    .freeze_i    (clamp_i),
    .fresh_i     (fresh_q),
    .ramp_i      (ramp_code),
    .sample_i    (samp_q),
    .preload_i   (ol_data_i),
    .acc_o       (acc_q),
    .code_next_o (loop_code)
  );

  // conversion gating with post-clamp hold
  logic hold_q, hold_d, conv_d;

  always_comb begin
    if (clamp_i)             hold_d = resume_hold_i;
    else if (conv_restart_i) hold_d = 1'b0;
    else                     hold_d = hold_q;
    conv_d = !clamp_i && !hold_d;
  end

  // output selection and alarm
  dac_src_e      src;
  logic [DW-1:0] dac_d;
  logic          alarm_d;

  always_comb begin
    if (clamp_i)        src = SRC_CLAMP;
    else if (loop_en_i) src = SRC_LOOP;
    else                src = SRC_OPEN;
    unique case (src)
      SRC_CLAMP: dac_d = clamp_code_i;
      SRC_LOOP:  dac_d = loop_code;
      default:   dac_d = ol_data_i;
    endcase
    alarm_d = alarm_en_i && (dac_d > alarm_thr_i);
  end

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) begin
      hold_q     <= 1'b0;
      conv_en_o  <= 1'b0;
      dac_code_o <= '0;
      alarm_o    <= 1'b0;
    end else begin
      hold_q     <= hold_d;
      conv_en_o  <= conv_d;
      dac_code_o <= dac_d;
      alarm_o    <= alarm_d;
    end
  end
endmodule

// File: rtl/bias_loop_chk.sv
module bias_loop_chk #(
  parameter int unsigned DW = 12,
  parameter int unsigned AW = 18
) (
  input logic          clk_i,
  input logic          core_rst_n,
  input logic          tick,
  input logic [AW-1:0] acc_q,
  input logic          loop_en_i,
  input logic          clamp_i,
  input logic [DW-1:0] ol_data_i,
  input logic [DW-1:0] clamp_code_i,
  input logic          alarm_en_i,
  input logic [DW-1:0] alarm_thr_i,
  input logic [DW-1:0] dac_code_o,
  input logic          conv_en_o,
  input logic          alarm_o
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) warm_q <= 2'b00;
    else             warm_q <= {warm_q[0], 1'b1};
  end
  logic live;
  assign live = core_rst_n && warm_q[1];

  // R2
  open_loop_follow_chk: assert property (@(posedge clk_i) disable iff (!live)
    ($past(!clamp_i && !loop_en_i)) |-> (dac_code_o == $past(ol_data_i)));

  // R3
  acc_moves_on_tick_chk: assert property (@(posedge clk_i) disable iff (!live)
    ($past(loop_en_i) && (acc_q != $past(acc_q))) |-> $past(tick));

  // R7
  clamp_code_out_chk: assert property (@(posedge clk_i) disable iff (!live)
    $past(clamp_i) |-> (dac_code_o == $past(clamp_code_i)));

  // R7
  clamp_freeze_chk: assert property (@(posedge clk_i) disable iff (!live)
    ($past(clamp_i) && $past(loop_en_i)) |-> $stable(acc_q));

  // R8
  clamp_stops_conv_chk: assert property (@(posedge clk_i) disable iff (!live)
    $past(clamp_i) |-> !conv_en_o);

  // R10
  alarm_cause_chk: assert property (@(posedge clk_i) disable iff (!live)
    alarm_o |-> ($past(alarm_en_i) && (dac_code_o > $past(alarm_thr_i))));
endmodule

bind bias_loop_ctrl bias_loop_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i        (clk_i),
  .core_rst_n   (core_rst_n),
  .tick         (tick),
  .acc_q        (acc_q),
  .loop_en_i    (loop_en_i),
  .clamp_i      (clamp_i),
  .ol_data_i    (ol_data_i),
  .clamp_code_i (clamp_code_i),
  .alarm_en_i   (alarm_en_i),
  .alarm_thr_i  (alarm_thr_i),
  .dac_code_o   (dac_code_o),
  .conv_en_o    (conv_en_o),
  .alarm_o      (alarm_o)
);

// File: tb/bias_loop_ctrl_bench.sv
module bias_loop_ctrl_bench;
  localparam int DW = 12;
  localparam int FR = 4;
  localparam int TK = 16;
  localparam int AMAX = (1 << (DW + FR)) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic loop_en, clamp, rhold, restart, adc_v, alarm_en;
  logic [3:0] rsel;
  logic [DW-1:0] sp, adc_d, ol, ccode, thr;
  logic [DW-1:0] dac;
  logic conv, alarm;

  always #2 clk = ~clk;

  bias_loop_ctrl #(.DW(DW), .FRAC_W(FR), .TICK_CYC(TK)) u_bias_loop_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .loop_en_i(loop_en), .clamp_i(clamp),
    .resume_hold_i(rhold), .conv_restart_i(restart), .setpoint_i(sp),
    .ramp_sel_i(rsel), .adc_valid_i(adc_v), .adc_data_i(adc_d),
    .ol_data_i(ol), .clamp_code_i(ccode), .alarm_en_i(alarm_en),
    .alarm_thr_i(thr), .dac_code_o(dac), .conv_en_o(conv), .alarm_o(alarm)
  );

  int checks = 0, errors = 0, cyc = 0;
  string dac_tag = "R3";

  // ---------------- reference model (from requirements) ----------------
  int m_rs0, m_rs1, m_cnt, m_ramp, m_samp, m_fresh, m_acc, m_dac, m_alarm, m_hold, m_conv;

  function automatic int step_of(int sel);
    int sh = (sel > DW - 1) ? DW - 1 : sel;
    return 1 << (DW - 1 - sh);
  endfunction

  function automatic int ramp_next(int cur, int tgt, int sel);
    int s = step_of(sel);
    if (tgt - cur > s) return cur + s;
    if (cur - tgt > s) return cur - s;
    return tgt;
  endfunction

  function automatic int acc_next(int acc, int ramp, int samp, bit en, bit tk, bit frz,
                                  bit fr, int pre);
    int s;
    if (!en) return pre << FR;
    if (!(tk && !frz && fr)) return acc;
    s = acc + (ramp - samp);
    if (s < 0) return 0;
    if (s > AMAX) return AMAX;
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs0 = 0; m_rs1 = 0; m_cnt = 0; m_ramp = 0; m_samp = 0; m_fresh = 0;
      m_acc = 0; m_dac = 0; m_alarm = 0; m_hold = 0; m_conv = 0;
    end else begin
      automatic int core = m_rs1;
      m_rs1 = m_rs0; m_rs0 = 1;
      if (!core) begin
        m_cnt = 0; m_ramp = 0; m_samp = 0; m_fresh = 0;
        m_acc = 0; m_dac = 0; m_alarm = 0; m_hold = 0; m_conv = 0;
      end else begin
        automatic bit tk = (m_cnt == TK - 1);
        automatic int n_acc = acc_next(m_acc, m_ramp, m_samp, loop_en, tk, clamp, m_fresh[0], int'(ol));
        automatic int n_hold = clamp ? int'(rhold) : (restart ? 0 : m_hold);
        m_ramp = tk ? ramp_next(m_ramp, int'(sp), int'(rsel)) : m_ramp;
        if (adc_v && m_conv != 0) begin m_samp = int'(adc_d); m_fresh = 1; end
        else if (tk) m_fresh = 0;
        m_acc = n_acc;
        m_dac = clamp ? int'(ccode) : (loop_en ? (n_acc >> FR) : int'(ol));
        m_alarm = (alarm_en && m_dac > int'(thr)) ? 1 : 0;
        m_hold = n_hold;
        m_conv = (!clamp && n_hold == 0) ? 1 : 0;
        m_cnt = tk ? 0 : m_cnt + 1;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    chk(int'(dac) == m_dac, clamp ? "R7" : (loop_en ? dac_tag : "R2"), int'(dac), m_dac);
    chk(int'(conv) == m_conv, rhold ? "R9" : "R8", int'(conv), m_conv);
    chk(int'(alarm) == m_alarm, "R10", int'(alarm), m_alarm);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pre;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; loop_en = 0; clamp = 0; rhold = 0; restart = 0; adc_v = 0;
    alarm_en = 0; rsel = 4'd0; sp = '0; adc_d = '0; ol = '0; ccode = '0; thr = '0;
    // R1: reset state, including while the synchronizer fills
    repeat (3) begin
      @(negedge clk);
      chk(dac == 0 && conv == 0 && alarm == 0, "R1", int'({dac, conv, alarm}), 0);
    end
    ol = 12'hABC; rst_n = 1'b1;
    step(); chk(dac == 0 && conv == 0, "R1", int'(dac), 0);
    step(); chk(dac == 0, "R1", int'(dac), 0);
    steps(3);
    // R2: open loop follows data
    chk(dac == 12'hABC, "R2", int'(dac), 12'hABC);
    ol = 12'h123; step();
    chk(dac == 12'h123, "R2", int'(dac), 12'h123);

    // R11 / R4: enabling loop starts at the open-loop code; no samples, no change
    dac_tag = "R11"; ol = 12'h400; step();
    loop_en = 1; sp = 12'h400; rsel = 4'd0;
    steps(3 * TK);
    chk(dac == 12'h400, "R11", int'(dac), 12'h400);
    dac_tag = "R4"; sp = 12'hFFF; steps(3 * TK);
    chk(dac == 12'h400, "R4", int'(dac), 12'h400);

    // R6: push to the top rail, then reverse
    dac_tag = "R6"; adc_v = 1; adc_d = 12'h000; steps(12 * TK);
    chk(dac == 12'hFFF, "R6", int'(dac), 12'hFFF);
    adc_d = 12'hFFF; sp = 12'hFEF; steps(3 * TK);
    chk(dac < 12'hFFF, "R6", int'(dac), 12'hFFE);
    adc_d = 12'hFEF; steps(TK);

    // R5: slow ramp toward a low setpoint with zero sample
    dac_tag = "R5"; rsel = 4'd9; sp = 12'h010; adc_d = 12'h000; steps(10 * TK);
    rsel = 4'd14; sp = 12'h800; steps(6 * TK);
    adc_v = 0; steps(TK);

    // R7/R8/R9: clamp with resume hold
    dac_tag = "R3"; pre = int'(dac);
    clamp = 1; rhold = 1; ccode = 12'h0F0; step();
    chk(dac == 12'h0F0, "R7", int'(dac), 12'h0F0);
    chk(conv == 0, "R8", int'(conv), 0);
    adc_v = 1; adc_d = 12'h000; steps(3 * TK);
    clamp = 0; adc_v = 0; step();
    chk(int'(dac) == pre, "R7", int'(dac), pre);
    adc_v = 1; steps(2 * TK);
    chk(conv == 0, "R9", int'(conv), 0);
    chk(int'(dac) == pre, "R9", int'(dac), pre);
    rhold = 0; restart = 1; step(); restart = 0;
    chk(conv == 1, "R9", int'(conv), 1);
    adc_v = 0;

    // R10: alarm threshold boundary in open loop
    loop_en = 0; ol = 12'h800; alarm_en = 1; thr = 12'h7FF; step();
    chk(alarm == 1, "R10", int'(alarm), 1);
    thr = 12'h800; step();
    chk(alarm == 0, "R10", int'(alarm), 0);
    thr = 12'h100; alarm_en = 0; step();
    chk(alarm == 0, "R10", int'(alarm), 0);

    // random mix: clamp, loop enable, strobes and ticks collide freely
    dac_tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 299) == 0) loop_en = ~loop_en;
      if ($urandom_range(0, 119) == 0) begin clamp = ~clamp; rhold = 1'($urandom_range(0, 1)); end
      restart = ($urandom_range(0, 39) == 0);
      if ($urandom_range(0, 199) == 0) begin sp = 12'($urandom_range(0, 4095)); rsel = 4'($urandom_range(0, 15)); end
      adc_v = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 9) == 0) adc_d = 12'($urandom_range(0, 4095));
      else begin
        automatic int v = m_dac + $urandom_range(0, 64) - 32;
        adc_d = 12'((v < 0) ? 0 : ((v > 4095) ? 4095 : v));
      end
      if ($urandom_range(0, 99) == 0) ol = 12'($urandom_range(0, 4095));
      if ($urandom_range(0, 99) == 0) ccode = 12'($urandom_range(0, 4095));
      if ($urandom_range(0, 149) == 0) begin alarm_en = 1'($urandom_range(0, 1)); thr = 12'($urandom_range(0, 4095)); end
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule